// File: doc/BRIEF.md
# Shared Register Transfer Bus with Encoded Source Select

This block is the data-movement fabric of a small accumulator datapath. A single 16-bit transfer bus links six working registers (a 12-bit address register, a 12-bit program counter, and four 16-bit registers: data, accumulator, instruction and temporary) and a 4096-word by 16-bit memory. A sequencer outside the block raises one request line for the source that should drive the bus. An OR-encoder turns that request into a 3-bit select code, and a multiplexer places the chosen source on the bus.

Every register that has its load control raised takes the bus value at the next rising clock edge. Several registers can load the same bus value in one cycle. The memory is always addressed by the address register. A write stores the current bus value at that address. The accumulator also has a second load path, used for results that come from an arithmetic unit outside the block. This lets a register-to-register transfer and an accumulator update happen in the same cycle. All control inputs are primary ports.

Top module: `xfer_bus_core`

## Requirements
- R1: The select code is the bitwise OR of fixed patterns. Bit 0 of the code is req1|req3|req5|req7, bit 1 is req2|req3|req6|req7, and bit 2 is req4|req5|req6|req7. Port `src_req` bit k-1 carries request k. Code 1 puts the address register on the bus, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the temporary register and 7 the memory word at the address register.
- R2: With select code 0 the bus carries all zeros.
- R3: When a 12-bit register is the bus source, bus bits 15..12 are zero. When a 12-bit register loads from the bus, it takes bus bits 11..0.
- R4: A register whose load input is high takes the bus value at the next rising edge, and several registers may load in the same cycle. A register with no control high keeps its value.
- R5: For each register, load beats clear and clear beats increment. Increment wraps from all ones to zero.
- R6: The instruction register has only a load control. It keeps its value in every cycle where its load is low.
- R7: When `mem_wr` is high, the bus value is stored at the word addressed by the address register at the rising edge. The word at any other address is unchanged.
- R8: With select code 7 the bus carries memory data only while `mem_rd` is high. Otherwise it carries zero.
- R9: The accumulator's external load takes `ac_ext_d` at the edge. It can happen in the same cycle as a bus load of another register. A bus load of the accumulator beats the external load, and the external load beats clear and increment.
- R10: An active-low reset clears all six registers to zero.
- R11: When more than one request is high, the OR-encoding applies unchanged. For example, requests 1 and 2 together select code 3, the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 7 | Source requests, bit k-1 = request k |
| mem_rd | input | 1 | Enables memory data onto the bus for code 7 |
| mem_wr | input | 1 | Stores bus value at the addressed word |
| ar_ld | input | 1 | Address register load from bus |
| ar_clr | input | 1 | Address register clear |
| ar_inr | input | 1 | Address register increment |
| pc_ld | input | 1 | Program counter load from bus |
| pc_clr | input | 1 | Program counter clear |
| pc_inr | input | 1 | Program counter increment |
| dr_ld | input | 1 | Data register load from bus |
| dr_clr | input | 1 | Data register clear |
| dr_inr | input | 1 | Data register increment |
| ac_ld | input | 1 | Accumulator load from bus |
| ac_clr | input | 1 | Accumulator clear |
| ac_inr | input | 1 | Accumulator increment |
| ac_ext_ld | input | 1 | Accumulator load from external result |
| ac_ext_d | input | 16 | External result for the accumulator |
| ir_ld | input | 1 | Instruction register load from bus |
| tr_ld | input | 1 | Temporary register load from bus |
| tr_clr | input | 1 | Temporary register clear |
| tr_inr | input | 1 | Temporary register increment |
| bus_sel | output | 3 | Encoded select code |
| bus_q | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Temporary register |

## Verification
The hardest condition to observe is that each source reaches the bus under its own code. A bus test only shows this when all six registers and the addressed memory word hold different values at the same time. The stimulus first fills every register from the accumulator in one broadcast load. It then alters each register through its own increment, clear or external path, and writes the temporary register into memory. Only after that does it walk a table of single and multiple requests. Memory isolation is shown by writing at one address and reading back another through the address register.

// File: rtl/xfer_bus_pkg.sv
package xfer_bus_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 12;
  localparam int NUM_REQ = 7;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } src_code_e;

  // widen a short register onto the bus with zero upper bits
  function automatic logic [DATA_W-1:0] widen(input logic [ADDR_W-1:0] v);
    return {{(DATA_W-ADDR_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/src_encoder.sv
module src_encoder #(
  parameter int NUM_REQ = 7,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req,
  output logic [SEL_W-1:0]   sel
);
  // mask of requests that set select bit b: request k sets bit b when k has bit b
  function automatic logic [NUM_REQ-1:0] bit_mask(input int b);
    logic [NUM_REQ-1:0] m;
    m = '0;
    for (int k = 1; k <= NUM_REQ; k++) m[k-1] = ((k >> b) & 1) == 1;
    return m;
  endfunction

  for (genvar b = 0; b < SEL_W; b++) begin : g_bit
    localparam logic [NUM_REQ-1:0] MASK = bit_mask(b);
    assign sel[b] = |(req & MASK);
  end

  AST_NO_REQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (sel == '0)); // R2
  AST_ONEHOT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(req) |-> (sel != '0) && req[sel - 1'b1]); // R1
endmodule

// File: rtl/xfer_reg.sv
module xfer_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  input  logic         alt_ld,
  input  logic [W-1:0] alt_d,
  input  logic         clr,
  input  logic         inr,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] next_val(
    input logic ld_i, input logic [W-1:0] d_i,
    input logic alt_i, input logic [W-1:0] alt_d_i,
    input logic clr_i, input logic inr_i, input logic [W-1:0] q_i);
    if (ld_i)       return d_i;
    else if (alt_i) return alt_d_i;
    else if (clr_i) return '0;
    else if (inr_i) return q_i + 1'b1;
    else            return q_i;
  endfunction

  logic [W-1:0] q_next;
  assign q_next = next_val(ld, d, alt_ld, alt_d, clr, inr, q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  AST_LD_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(d))); // R4
  AST_ALT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && alt_ld) |=> (q == $past(alt_d))); // R9
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !alt_ld && clr) |=> (q == '0)); // R5
  AST_INR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !alt_ld && !clr && inr) |=> (q == $past(q) + 1'b1)); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !alt_ld && !clr && !inr) |=> $stable(q)); // R4
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wdata;
  end
  assign rdata = cells[addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (addr != $past(addr)) || (rdata == $past(wdata))); // R7
endmodule

// File: rtl/bus_select.sv
module bus_select
  import xfer_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              mem_rd,
  input  logic [ADDR_W-1:0] ar,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] dr,
  input  logic [DATA_W-1:0] ac,
  input  logic [DATA_W-1:0] ir,
  input  logic [DATA_W-1:0] tr,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] bus
);
  always_comb begin
    unique case (src_code_e'(sel))
      SRC_AR:  bus = widen(ar);
      SRC_PC:  bus = widen(pc);
      SRC_DR:  bus = dr;
      SRC_AC:  bus = ac;
      SRC_IR:  bus = ir;
      SRC_TR:  bus = tr;
      SRC_MEM: bus = mem_rd ? mem_data : '0;
      default: bus = '0;
    endcase
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_NONE) |-> (bus == '0)); // R2
  AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_AR || sel == SRC_PC) |-> (bus[DATA_W-1:ADDR_W] == '0)); // R3
  AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_MEM && !mem_rd) |-> (bus == '0)); // R8
endmodule

// File: rtl/xfer_bus_core.sv
module xfer_bus_core
  import xfer_bus_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] src_req,
  input  logic               mem_rd,
  input  logic               mem_wr,
  input  logic               ar_ld,
  input  logic               ar_clr,
  input  logic               ar_inr,
  input  logic               pc_ld,
  input  logic               pc_clr,
  input  logic               pc_inr,
  input  logic               dr_ld,
  input  logic               dr_clr,
  input  logic               dr_inr,
  input  logic               ac_ld,
  input  logic               ac_clr,
  input  logic               ac_inr,
  input  logic               ac_ext_ld,
  input  logic [DATA_W-1:0]  ac_ext_d,
  input  logic               ir_ld,
  input  logic               tr_ld,
  input  logic               tr_clr,
  input  logic               tr_inr,
  output logic [SEL_W-1:0]   bus_sel,
  output logic [DATA_W-1:0]  bus_q,
  output logic [ADDR_W-1:0]  ar_q,
  output logic [ADDR_W-1:0]  pc_q,
  output logic [DATA_W-1:0]  dr_q,
  output logic [DATA_W-1:0]  ac_q,
  output logic [DATA_W-1:0]  ir_q,
  output logic [DATA_W-1:0]  tr_q
);
  logic [DATA_W-1:0] mem_word;
  logic [ADDR_W-1:0] bus_lo;
  assign bus_lo = bus_q[ADDR_W-1:0];

  src_encoder #(.NUM_REQ(NUM_REQ), .SEL_W(SEL_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .req(src_req), .sel(bus_sel));

  bus_select u_mux (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .mem_rd(mem_rd),
    .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(ac_q), .ir(ir_q), .tr(tr_q),
    .mem_data(mem_word), .bus(bus_q));

  word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr(ar_q), .wr_en(mem_wr),
    .wdata(bus_q), .rdata(mem_word));

  xfer_reg #(.W(ADDR_W)) u_ar (
    .clk(clk), .rst_n(rst_n), .ld(ar_ld), .d(bus_lo), .alt_ld(1'b0),
    .alt_d('0), .clr(ar_clr), .inr(ar_inr), .q(ar_q));

  xfer_reg #(.W(ADDR_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .ld(pc_ld), .d(bus_lo), .alt_ld(1'b0),
    .alt_d('0), .clr(pc_clr), .inr(pc_inr), .q(pc_q));

  xfer_reg #(.W(DATA_W)) u_dr (
    .clk(clk), .rst_n(rst_n), .ld(dr_ld), .d(bus_q), .alt_ld(1'b0),
    .alt_d('0), .clr(dr_clr), .inr(dr_inr), .q(dr_q));

  xfer_reg #(.W(DATA_W)) u_ac (
    .clk(clk), .rst_n(rst_n), .ld(ac_ld), .d(bus_q), .alt_ld(ac_ext_ld),
    .alt_d(ac_ext_d), .clr(ac_clr), .inr(ac_inr), .q(ac_q));

  // instruction register: load only
  xfer_reg #(.W(DATA_W)) u_ir (
    .clk(clk), .rst_n(rst_n), .ld(ir_ld), .d(bus_q), .alt_ld(1'b0),
    .alt_d('0), .clr(1'b0), .inr(1'b0), .q(ir_q));

  xfer_reg #(.W(DATA_W)) u_tr (
    .clk(clk), .rst_n(rst_n), .ld(tr_ld), .d(bus_q), .alt_ld(1'b0),
    .alt_d('0), .clr(tr_clr), .inr(tr_inr), .q(tr_q));

  AST_IR_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_ld |=> $stable(ir_q)); // R6
  AST_SHORT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ar_ld |=> (ar_q == $past(bus_q[ADDR_W-1:0]))); // R3
endmodule

// File: tb/xfer_bus_core_test.sv
module xfer_bus_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] src_req = '0;
  logic mem_rd = 0, mem_wr = 0;
  logic ar_ld = 0, ar_clr = 0, ar_inr = 0;
  logic pc_ld = 0, pc_clr = 0, pc_inr = 0;
  logic dr_ld = 0, dr_clr = 0, dr_inr = 0;
  logic ac_ld = 0, ac_clr = 0, ac_inr = 0, ac_ext_ld = 0;
  logic [15:0] ac_ext_d = '0;
  logic ir_ld = 0;
  logic tr_ld = 0, tr_clr = 0, tr_inr = 0;
  logic [2:0]  bus_sel;
  logic [15:0] bus_q, dr_q, ac_q, ir_q, tr_q;
  logic [11:0] ar_q, pc_q;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xfer_bus_core uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ar_ld(ar_ld), .ar_clr(ar_clr), .ar_inr(ar_inr),
    .pc_ld(pc_ld), .pc_clr(pc_clr), .pc_inr(pc_inr),
    .dr_ld(dr_ld), .dr_clr(dr_clr), .dr_inr(dr_inr),
    .ac_ld(ac_ld), .ac_clr(ac_clr), .ac_inr(ac_inr),
    .ac_ext_ld(ac_ext_ld), .ac_ext_d(ac_ext_d), .ir_ld(ir_ld),
    .tr_ld(tr_ld), .tr_clr(tr_clr), .tr_inr(tr_inr),
    .bus_sel(bus_sel), .bus_q(bus_q), .ar_q(ar_q), .pc_q(pc_q),
    .dr_q(dr_q), .ac_q(ac_q), .ir_q(ir_q), .tr_q(tr_q));

  // {req[6:0], mem_rd, expected select[2:0], expected bus[15:0]}
  localparam int NV = 14;
  localparam logic [26:0] VEC [NV] = '{
    {7'b0000000, 1'b0, 3'd0, 16'h0000},  // R2 no request
    {7'b0000000, 1'b1, 3'd0, 16'h0000},  // R2 read enable alone
    {7'b0000001, 1'b0, 3'd1, 16'h05C3},  // R1 R3 address register
    {7'b0000010, 1'b0, 3'd2, 16'h05C4},  // R1 R3 program counter
    {7'b0000100, 1'b0, 3'd3, 16'h0001},  // R1 data register
    {7'b0001000, 1'b0, 3'd4, 16'h1234},  // R1 accumulator
    {7'b0010000, 1'b0, 3'd5, 16'hA5C3},  // R1 instruction register
    {7'b0100000, 1'b0, 3'd6, 16'hA5C4},  // R1 temporary register
    {7'b1000000, 1'b1, 3'd7, 16'hA5C4},  // R1 R7 memory word
    {7'b1000000, 1'b0, 3'd7, 16'h0000},  // R8 gated memory
    {7'b0000011, 1'b0, 3'd3, 16'h0001},  // R11 1|2 -> 3
    {7'b0001010, 1'b0, 3'd6, 16'hA5C4},  // R11 2|4 -> 6
    {7'b0001001, 1'b0, 3'd5, 16'hA5C3},  // R11 1|4 -> 5
    {7'b1000001, 1'b1, 3'd7, 16'hA5C4}   // R11 1|7 -> 7
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_ctl();
    src_req = '0; mem_rd = 0; mem_wr = 0;
    ar_ld = 0; ar_clr = 0; ar_inr = 0; pc_ld = 0; pc_clr = 0; pc_inr = 0;
    dr_ld = 0; dr_clr = 0; dr_inr = 0; ac_ld = 0; ac_clr = 0; ac_inr = 0;
    ac_ext_ld = 0; ir_ld = 0; tr_ld = 0; tr_clr = 0; tr_inr = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; clear_ctl();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 ar", {4'h0, ar_q}, 16'h0); chk("R10 pc", {4'h0, pc_q}, 16'h0);
    chk("R10 dr", dr_q, 16'h0); chk("R10 ac", ac_q, 16'h0);
    chk("R10 ir", ir_q, 16'h0); chk("R10 tr", tr_q, 16'h0);
    rst_n = 1;
    @(posedge clk); #1;

    ac_ext_ld = 1; ac_ext_d = 16'hA5C3; tick();
    chk("R9 ext load", ac_q, 16'hA5C3);

    // R4 broadcast load from the accumulator
    src_req = 7'b0001000; ar_ld = 1; pc_ld = 1; dr_ld = 1; ir_ld = 1; tr_ld = 1; tick();
    chk("R3 ar low bits", {4'h0, ar_q}, 16'h05C3);
    chk("R4 pc", {4'h0, pc_q}, 16'h05C3);
    chk("R4 dr", dr_q, 16'hA5C3); chk("R4 ir", ir_q, 16'hA5C3);
    chk("R4 tr", tr_q, 16'hA5C3);

    ac_ext_ld = 1; ac_ext_d = 16'h1234; tick();
    pc_inr = 1; tr_inr = 1; dr_clr = 1; dr_inr = 1; tick();
    chk("R5 pc inr", {4'h0, pc_q}, 16'h05C4);
    chk("R5 tr inr", tr_q, 16'hA5C4);
    chk("R5 clr over inr", dr_q, 16'h0000);
    dr_inr = 1; tick();
    src_req = 7'b0100000; mem_wr = 1; tick();  // R7 M[5C3] <= A5C4

    for (int i = 0; i < NV; i++) begin
      src_req = VEC[i][26:20]; mem_rd = VEC[i][19];
      #1;
      chk($sformatf("R1/R2/R8/R11 sel row %0d", i), {13'h0, bus_sel}, {13'h0, VEC[i][18:16]});
      chk($sformatf("R1/R2/R8/R11 bus row %0d", i), bus_q, VEC[i][15:0]);
      clear_ctl();
      #1;
    end

    // R5 priority ld > clr > inr; R3 truncation; R6 IR holds
    src_req = 7'b0001000; pc_ld = 1; pc_clr = 1; pc_inr = 1; ar_ld = 1; tick();
    chk("R5 ld wins", {4'h0, pc_q}, 16'h0234);
    chk("R6 ir holds", ir_q, 16'hA5C3);

    // R9 simultaneous bus load and external load
    src_req = 7'b0001000; dr_ld = 1; ac_ext_ld = 1; ac_ext_d = 16'h5555; tick();
    chk("R9 dr from bus", dr_q, 16'h1234);
    chk("R9 ac external", ac_q, 16'h5555);
    src_req = 7'b0000010; ac_ld = 1; ac_ext_ld = 1; ac_ext_d = 16'h7777; tick();
    chk("R9 bus beats external", ac_q, 16'h0234);

    // R5 wrap
    ac_ext_ld = 1; ac_ext_d = 16'hFFFF; tick();
    src_req = 7'b0001000; ar_ld = 1; tick();
    chk("R3 ar from FFFF", {4'h0, ar_q}, 16'h0FFF);
    ar_inr = 1; ac_inr = 1; tick();
    chk("R5 ar wrap", {4'h0, ar_q}, 16'h0000);
    chk("R5 ac wrap", ac_q, 16'h0000);

    // R7 write at 0, other address untouched
    ac_ext_ld = 1; ac_ext_d = 16'h0BEE; tick();
    src_req = 7'b0001000; mem_wr = 1; tick();
    src_req = 7'b1000000; mem_rd = 1; #1;
    chk("R7 read back", bus_q, 16'h0BEE);
    clear_ctl();
    src_req = 7'b0010000; pc_ld = 1; tick();
    src_req = 7'b0000010; ar_ld = 1; tick();
    src_req = 7'b1000000; mem_rd = 1; #1;
    chk("R7 other word intact", bus_q, 16'hA5C4);
    clear_ctl();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule